// File: doc/BRIEF.md
# Dual-Channel Threshold Alarm Monitor

This block watches two measurement channels. Each channel supplies a temperature reading and a current reading as 12-bit codes that are already converted. Each code is checked against a pair of limits that software programs. Temperature codes are signed two's complement with an LSB of 0.125 °C. Current codes are unsigned ADC codes.

When a limit is crossed, a sticky per-source flag is set. A single alarm output reports the condition in one of two styles, chosen by a bit in the alarm control register:

- In interrupt style, the first crossing latches the output until software reads the flags.
- In comparator style, the output tracks whether the most recent samples lie outside their windows.

Software reaches every limit and the control register as 16-bit words through a simple register port. The read port has a latency of one cycle. A one-shot clear bit in the control register returns every limit and every flag to the power-on state. The power-on limits are chosen so that no sample can cross them.

Register addresses:

| Address | Register |
|---|---|
| 4·ch+0 | temperature upper limit |
| 4·ch+1 | temperature lower limit |
| 4·ch+2 | current upper limit |
| 4·ch+3 | current lower limit |
| 8 | control |
| 9 | flags |

Control register bits:

| Bit | Name | Meaning |
|---|---|---|
| 0 | clear | write 1 to clear |
| 1 | style | 1 = comparator style, 0 = interrupt style |
| 2 | channel 0 enable | |
| 3 | channel 1 enable | |

Flag bits: bit 2·ch is the temperature flag of channel ch, and bit 2·ch+1 is its current flag.

Top module: `tam_monitor`

## Requirements
- R1: After reset the registers read as follows, and `alarm_o` is 0:

  | Register | Value |
  |---|---|
  | temperature upper limits | 0x07FF |
  | temperature lower limits | 0x0800 (−256 °C) |
  | current upper limits | 0x0FFF |
  | current lower limits | 0x0000 |
  | control | 0x000C (interrupt style, both channels enabled) |
  | flags | 0x0000 |

- R2: A write to a limit register stores bits 11:0. Bits 15:12 of the write are ignored, and those bits always read back as 0.
- R3: A temperature sample is a violation when, compared as signed values, it is strictly above its upper limit or strictly below its lower limit. A sample equal to either limit is not a violation.
- R4: A current sample is a violation when, compared as unsigned values, it is strictly above its upper limit or strictly below its lower limit. A sample equal to either limit is not a violation.
- R5: A violation on an enabled channel sets its flag bit. The flag stays set while later samples fall inside the window.
- R6: A read of the flags register returns the flags and clears them. A violation in the same cycle as that read leaves its flag set after the read.
- R7: In interrupt style, `alarm_o` is 1 whenever any flag is set, and it stays 1 until the flags are read or cleared.
- R8: In comparator style, `alarm_o` is 1 while the latest sample of any source on an enabled channel is a violation. It falls once every such latest sample is back inside its window.
- R9: Samples on a disabled channel set no flag and raise no comparator-style alarm.
- R10: Writing control bit 0 as 1 restores all limits to their reset values and clears all flags and comparator state. Bits 3:1 of the same write take effect normally. Bit 0 always reads 0.
- R11: If a clear and a violating sample arrive in the same cycle, the clear wins: the flags are 0 afterwards and `alarm_o` is 0.
- R12: Control bits 15:4 are ignored on write and read as 0. Writes to the flags address have no effect.
- R13: `reg_rdata` shows the addressed register in the cycle after `reg_rd_en`, and it holds its value while no read is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, one cycle after the strobe |
| smp_vld | input | 1 | Sample valid |
| smp_ch | input | 1 | Sample channel |
| smp_is_cur | input | 1 | 1 for a current sample, 0 for a temperature sample |
| smp_code | input | 12 | Sample code |
| alarm_o | output | 1 | Alarm output |

## Verification
Two pairs of events can land on the same clock edge, and each is tested by driving both on the same cycle:

- **Flag read and violating sample.** The bench raises a flag-register read and a violating sample together. It expects the read data to show the old flags, and a second read to show the new flag still set.
- **Clear and violating sample.** The bench issues a control write carrying the clear bit together with a violating sample. It expects no flag, a low alarm, and limits back at their reset values.

The signed-versus-unsigned choice is tested with codes that only the correct comparison keeps inside the window.

// File: rtl/tam_pkg.sv
package tam_pkg;
  localparam int unsigned LIMS_PER_CH = 4;
  localparam int unsigned LIM_T_HI    = 0;
  localparam int unsigned LIM_T_LO    = 1;
  localparam int unsigned LIM_I_HI    = 2;
  localparam int unsigned LIM_I_LO    = 3;
  localparam int unsigned CFG_CLR_BIT  = 0;
  localparam int unsigned CFG_MODE_BIT = 1;
  localparam int unsigned CFG_EN_LSB   = 2;
endpackage

// File: rtl/tam_rst_sync.sv
module tam_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/tam_regfile.sv
module tam_regfile
  import tam_pkg::*;
#(
  parameter int unsigned NUM_CH = 2,
  parameter int unsigned CODE_W = 12,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 4
) (
  input  logic                                        clk,
  input  logic                                        rst_n,
  input  logic                                        wr_en,
  input  logic [ADDR_W-1:0]                           addr,
  input  logic [DATA_W-1:0]                           wdata,
  output logic [NUM_CH*LIMS_PER_CH-1:0][CODE_W-1:0]   lim_o,
  output logic                                        mode_o,
  output logic [NUM_CH-1:0]                           chen_o,
  output logic                                        clr_o
);
  localparam int unsigned NLIM = NUM_CH * LIMS_PER_CH;
  localparam logic [ADDR_W-1:0] CFG_ADDR = ADDR_W'(NLIM);

  logic cfg_hit;
  assign cfg_hit = wr_en && (addr == CFG_ADDR);
  assign clr_o   = cfg_hit && wdata[CFG_CLR_BIT];

  for (genvar g = 0; g < NLIM; g++) begin : g_lim
    localparam int unsigned KIND = g % LIMS_PER_CH;
    localparam logic [CODE_W-1:0] POR_VAL =
      (KIND == LIM_T_HI) ? {1'b0, {(CODE_W-1){1'b1}}} :
      (KIND == LIM_T_LO) ? {1'b1, {(CODE_W-1){1'b0}}} :
      (KIND == LIM_I_HI) ? {CODE_W{1'b1}} : {CODE_W{1'b0}};
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(g);

    logic              hit, ld;
    logic [CODE_W-1:0] lim_d, lim_q;

    always_comb begin
      hit   = wr_en && (addr == MY_ADDR);
      ld    = hit || clr_o;
      lim_d = clr_o ? POR_VAL : wdata[CODE_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  lim_q <= POR_VAL;
      else if (ld) lim_q <= lim_d;
    end

    assign lim_o[g] = lim_q;
  end

  logic              mode_d, mode_q;
  logic [NUM_CH-1:0] chen_d, chen_q;

  always_comb begin
    mode_d = wdata[CFG_MODE_BIT];
    chen_d = wdata[CFG_EN_LSB +: NUM_CH];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      chen_q <= '1;
    end else if (cfg_hit) begin
      mode_q <= mode_d;
      chen_q <= chen_d;
    end
  end

  assign mode_o = mode_q;
  assign chen_o = chen_q;
endmodule

// File: rtl/tam_window_cmp.sv
module tam_window_cmp #(
  parameter int unsigned CODE_W = 12
) (
  input  logic [CODE_W-1:0] code_i,
  input  logic              is_cur_i,
  input  logic [CODE_W-1:0] t_hi_i,
  input  logic [CODE_W-1:0] t_lo_i,
  input  logic [CODE_W-1:0] i_hi_i,
  input  logic [CODE_W-1:0] i_lo_i,
  output logic              out_o
);
  logic t_out, i_out;

  always_comb begin
    t_out = ($signed(code_i) > $signed(t_hi_i)) || ($signed(code_i) < $signed(t_lo_i));
    i_out = (code_i > i_hi_i) || (code_i < i_lo_i);
    out_o = is_cur_i ? i_out : t_out;
  end
endmodule

// File: rtl/tam_alarm_ctrl.sv
module tam_alarm_ctrl #(
  parameter int unsigned NUM_CH = 2,
  parameter int unsigned CH_W   = 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  smp_vld,
  input  logic [CH_W-1:0]       smp_ch,
  input  logic                  smp_is_cur,
  input  logic [NUM_CH-1:0]     viol_i,
  input  logic [NUM_CH-1:0]     chen_i,
  input  logic                  mode_i,
  input  logic                  clr_i,
  input  logic                  flag_rd_i,
  output logic [2*NUM_CH-1:0]   flags_o,
  output logic                  alarm_o
);
  localparam int unsigned NSRC = 2 * NUM_CH;

  logic [NSRC-1:0] upd, hit, en_mask;
  logic [NSRC-1:0] stat_d, stat_q, flag_d, flag_q;
  logic            stat_ld, flag_ld;

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    localparam int unsigned CH   = s / 2;
    localparam logic        KIND = 1'((s % 2) == 1);
    assign upd[s]     = smp_vld && (32'(smp_ch) == CH) && (smp_is_cur == KIND);
    assign hit[s]     = upd[s] && viol_i[CH] && chen_i[CH];
    assign en_mask[s] = chen_i[CH];
  end

  always_comb begin
    stat_ld = clr_i || smp_vld;
    stat_d  = clr_i ? '0 : ((stat_q & ~upd) | (upd & hit));
    flag_ld = clr_i || flag_rd_i || (|hit);
    if (clr_i)          flag_d = '0;
    else if (flag_rd_i) flag_d = hit;
    else                flag_d = flag_q | hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       stat_q <= '0;
    else if (stat_ld) stat_q <= stat_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= '0;
    else if (flag_ld) flag_q <= flag_d;
  end

  assign flags_o = flag_q;
  assign alarm_o = mode_i ? |(stat_q & en_mask) : |flag_q;
endmodule

// File: rtl/tam_monitor.sv
module tam_monitor
  import tam_pkg::*;
#(
  parameter int unsigned NUM_CH = 2,
  parameter int unsigned CODE_W = 12,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 4,
  localparam int unsigned CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic              reg_rd_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              smp_vld,
  input  logic [CH_W-1:0]   smp_ch,
  input  logic              smp_is_cur,
  input  logic [CODE_W-1:0] smp_code,
  output logic              alarm_o
);
  localparam int unsigned NLIM  = NUM_CH * LIMS_PER_CH;
  localparam int unsigned NSRC  = 2 * NUM_CH;
  localparam int unsigned IDX_W = $clog2(NLIM);
  localparam logic [ADDR_W-1:0] CFG_ADDR  = ADDR_W'(NLIM);
  localparam logic [ADDR_W-1:0] FLAG_ADDR = ADDR_W'(NLIM + 1);

  logic                          rst_n_int;
  logic [NLIM-1:0][CODE_W-1:0]   lim_w;
  logic                          cfg_mode_w, clr_w, flag_rd_w;
  logic [NUM_CH-1:0]             chen_w, viol_w;
  logic [NSRC-1:0]               flags_w;
  logic [DATA_W-1:0]             rd_d, rd_q;

  tam_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_int)
  );

  tam_regfile #(.NUM_CH(NUM_CH), .CODE_W(CODE_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n_int), .wr_en(reg_wr_en), .addr(reg_addr), .wdata(reg_wdata),
    .lim_o(lim_w), .mode_o(cfg_mode_w), .chen_o(chen_w), .clr_o(clr_w)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    tam_window_cmp #(.CODE_W(CODE_W)) u_cmp (
      .code_i(smp_code), .is_cur_i(smp_is_cur),
      .t_hi_i(lim_w[c*LIMS_PER_CH + LIM_T_HI]),
      .t_lo_i(lim_w[c*LIMS_PER_CH + LIM_T_LO]),
      .i_hi_i(lim_w[c*LIMS_PER_CH + LIM_I_HI]),
      .i_lo_i(lim_w[c*LIMS_PER_CH + LIM_I_LO]),
      .out_o(viol_w[c])
    );
  end

  assign flag_rd_w = reg_rd_en && (reg_addr == FLAG_ADDR);

  tam_alarm_ctrl #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_alarm (
    .clk(clk), .rst_n(rst_n_int), .smp_vld(smp_vld), .smp_ch(smp_ch),
    .smp_is_cur(smp_is_cur), .viol_i(viol_w), .chen_i(chen_w), .mode_i(cfg_mode_w),
    .clr_i(clr_w), .flag_rd_i(flag_rd_w), .flags_o(flags_w), .alarm_o(alarm_o)
  );

  always_comb begin
    rd_d = '0;
    if (reg_addr < CFG_ADDR) begin
      rd_d[CODE_W-1:0] = lim_w[reg_addr[IDX_W-1:0]];
    end else if (reg_addr == CFG_ADDR) begin
      rd_d[CFG_MODE_BIT]          = cfg_mode_w;
      rd_d[CFG_EN_LSB +: NUM_CH]  = chen_w;
    end else if (reg_addr == FLAG_ADDR) begin
      rd_d[NSRC-1:0] = flags_w;
    end
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int)     rd_q <= '0;
    else if (reg_rd_en) rd_q <= rd_d;
  end

  assign reg_rdata = rd_q;
endmodule

// File: rtl/tam_monitor_chk.sv
module tam_monitor_chk #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CODE_W = 12,
  parameter int unsigned NSRC   = 4,
  parameter int unsigned NLIM   = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr_en,
  input logic              reg_rd_en,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              smp_vld,
  input logic              alarm_o,
  input logic [NSRC-1:0]   flags,
  input logic              mode
);
  localparam logic [ADDR_W-1:0] CFG_ADDR  = ADDR_W'(NLIM);
  localparam logic [ADDR_W-1:0] FLAG_ADDR = ADDR_W'(NLIM + 1);

  logic clr, cfg_wr, flag_rd;
  assign cfg_wr  = reg_wr_en && (reg_addr == CFG_ADDR);
  assign clr     = cfg_wr && reg_wdata[0];
  assign flag_rd = reg_rd_en && (reg_addr == FLAG_ADDR);

  AST_CLR_QUIETS_ALARM: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !alarm_o); // R10
  AST_CLR_BEATS_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && smp_vld) |=> (flags == '0)); // R11
  AST_READ_EMPTIES_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_rd && !smp_vld && !clr) |=> (flags == '0)); // R6
  AST_NO_SET_WITHOUT_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_vld |=> ((flags & ~$past(flags)) == '0)); // R5
  AST_INT_ALARM_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode && alarm_o && !flag_rd && !cfg_wr) |=> alarm_o); // R7
  AST_CMP_ALARM_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode && !smp_vld && !reg_wr_en) |=> $stable(alarm_o)); // R8
  AST_RDATA_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd_en |=> (reg_rdata[DATA_W-1:CODE_W] == '0)); // R2
  AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd_en |=> $stable(reg_rdata)); // R13
endmodule

bind tam_monitor tam_monitor_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CODE_W(CODE_W), .NSRC(NSRC), .NLIM(NLIM)
) chk_i (
  .clk(clk), .rst_n(rst_n_int), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
  .smp_vld(smp_vld), .alarm_o(alarm_o), .flags(flags_w), .mode(cfg_mode_w)
);

// File: tb/tam_monitor_tb_top.sv
`timescale 1ns/1ps
module tam_monitor_tb_top;
  localparam logic [3:0] A_TH0 = 4'd0, A_TL0 = 4'd1, A_IH0 = 4'd2, A_IL0 = 4'd3;
  localparam logic [3:0] A_TH1 = 4'd4, A_TL1 = 4'd5, A_IH1 = 4'd6, A_IL1 = 4'd7;
  localparam logic [3:0] A_CFG = 4'd8, A_FLG = 4'd9;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0, reg_rd_en = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        smp_vld = 1'b0, smp_ch = 1'b0, smp_is_cur = 1'b0;
  logic [11:0] smp_code = '0;
  logic        alarm_o;
  int          n_vec = 0, n_err = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  tam_monitor dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .smp_vld(smp_vld), .smp_ch(smp_ch), .smp_is_cur(smp_is_cur),
    .smp_code(smp_code), .alarm_o(alarm_o)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_rd_en = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd_en = 1'b0;
    d = reg_rdata;
  endtask

  task automatic smp(input logic ch, input logic cur, input logic [11:0] code);
    @(negedge clk);
    smp_vld = 1'b1; smp_ch = ch; smp_is_cur = cur; smp_code = code;
    @(negedge clk);
    smp_vld = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [3:0] a, input logic [15:0] exp);
    logic [15:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  // Control bits: 0 clear, 1 comparator style, 3:2 channel enables
  task automatic soft_clear(input logic [15:0] cfg);
    wr(A_CFG, cfg | 16'h0001);
  endtask

  task automatic t_reset;
    chk("R1 alarm", {15'd0, alarm_o}, 16'h0000);
    rd_chk("R1 TH0", A_TH0, 16'h07FF); rd_chk("R1 TL0", A_TL0, 16'h0800);
    rd_chk("R1 IH0", A_IH0, 16'h0FFF); rd_chk("R1 IL0", A_IL0, 16'h0000);
    rd_chk("R1 TH1", A_TH1, 16'h07FF); rd_chk("R1 TL1", A_TL1, 16'h0800);
    rd_chk("R1 IH1", A_IH1, 16'h0FFF); rd_chk("R1 IL1", A_IL1, 16'h0000);
    rd_chk("R1 CFG", A_CFG, 16'h000C); rd_chk("R1 FLG", A_FLG, 16'h0000);
  endtask

  task automatic t_write_masks;
    logic [15:0] d;
    wr(A_TH0, 16'hF123); rd_chk("R2 TH0 upper ignored", A_TH0, 16'h0123);
    wr(A_IL1, 16'hAABC); rd_chk("R2 IL1 upper ignored", A_IL1, 16'h0ABC);
    wr(A_CFG, 16'hF00E); rd_chk("R12 CFG upper ignored", A_CFG, 16'h000E);
    wr(A_FLG, 16'hFFFF); rd_chk("R12 FLG write ignored", A_FLG, 16'h0000);
    rd(A_TH0, d);
    repeat (3) @(negedge clk);
    chk("R13 rdata holds", reg_rdata, 16'h0123);
    soft_clear(16'h000C);
  endtask

  task automatic t_temp_cmp;
    soft_clear(16'h000C);
    wr(A_TH0, 16'h00C8); wr(A_TL0, 16'h0FF0);
    smp(1'b0, 1'b0, 12'h0C8); rd_chk("R3 equal upper", A_FLG, 16'h0000);
    smp(1'b0, 1'b0, 12'hFF0); rd_chk("R3 equal lower", A_FLG, 16'h0000);
    smp(1'b0, 1'b0, 12'h005); rd_chk("R3 signed inside", A_FLG, 16'h0000);
    smp(1'b0, 1'b0, 12'h0C9); rd_chk("R3 above upper", A_FLG, 16'h0001);
    smp(1'b0, 1'b0, 12'hF00); rd_chk("R3 below lower", A_FLG, 16'h0001);
  endtask

  task automatic t_cur_cmp;
    soft_clear(16'h000C);
    wr(A_IH1, 16'h0800); wr(A_IL1, 16'h0100);
    smp(1'b1, 1'b1, 12'h800); rd_chk("R4 equal upper", A_FLG, 16'h0000);
    smp(1'b1, 1'b1, 12'h100); rd_chk("R4 equal lower", A_FLG, 16'h0000);
    smp(1'b1, 1'b1, 12'h7FF); rd_chk("R4 unsigned inside", A_FLG, 16'h0000);
    smp(1'b1, 1'b1, 12'h0FF); rd_chk("R4 below lower", A_FLG, 16'h0008);
    smp(1'b1, 1'b1, 12'h900); rd_chk("R4 above upper", A_FLG, 16'h0008);
  endtask

  task automatic t_sticky_int;
    soft_clear(16'h000C);
    wr(A_IH0, 16'h0200);
    smp(1'b0, 1'b1, 12'h300);
    chk("R7 alarm set", {15'd0, alarm_o}, 16'h0001);
    smp(1'b0, 1'b1, 12'h100);
    repeat (2) @(negedge clk);
    chk("R7 alarm held", {15'd0, alarm_o}, 16'h0001);
    rd_chk("R5 flag sticky", A_FLG, 16'h0002);
    chk("R7 alarm cleared by read", {15'd0, alarm_o}, 16'h0000);
  endtask

  task automatic t_cmp_mode;
    soft_clear(16'h000E);
    wr(A_TH1, 16'h0040);
    smp(1'b1, 1'b0, 12'h041);
    chk("R8 alarm on violation", {15'd0, alarm_o}, 16'h0001);
    smp(1'b1, 1'b0, 12'h020);
    chk("R8 alarm drops in window", {15'd0, alarm_o}, 16'h0000);
    rd_chk("R5 flag kept in comparator style", A_FLG, 16'h0004);
  endtask

  task automatic t_disabled;
    soft_clear(16'h000A);
    wr(A_TH0, 16'h0010);
    smp(1'b0, 1'b0, 12'h050);
    chk("R9 no comparator alarm", {15'd0, alarm_o}, 16'h0000);
    rd_chk("R9 no flag", A_FLG, 16'h0000);
  endtask

  task automatic t_read_race;
    soft_clear(16'h000C);
    wr(A_TH0, 16'h0010);
    @(negedge clk);
    reg_rd_en = 1'b1; reg_addr = A_FLG;
    smp_vld = 1'b1; smp_ch = 1'b0; smp_is_cur = 1'b0; smp_code = 12'h020;
    @(negedge clk);
    reg_rd_en = 1'b0; smp_vld = 1'b0;
    chk("R6 read returns old flags", reg_rdata, 16'h0000);
    rd_chk("R6 same-cycle violation kept", A_FLG, 16'h0001);
    rd_chk("R6 read clears", A_FLG, 16'h0000);
  endtask

  task automatic t_soft_clear;
    soft_clear(16'h000C);
    wr(A_TL1, 16'h0100); wr(A_IH0, 16'h0300);
    smp(1'b1, 1'b0, 12'h050);
    wr(A_CFG, 16'h0007);
    chk("R10 alarm low after clear", {15'd0, alarm_o}, 16'h0000);
    rd_chk("R10 TL1 restored", A_TL1, 16'h0800);
    rd_chk("R10 IH0 restored", A_IH0, 16'h0FFF);
    rd_chk("R10 clear bit reads 0", A_CFG, 16'h0006);
    rd_chk("R10 flags cleared", A_FLG, 16'h0000);
  endtask

  task automatic t_clear_race;
    soft_clear(16'h000C);
    wr(A_TH0, 16'h0010);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = A_CFG; reg_wdata = 16'h000D;
    smp_vld = 1'b1; smp_ch = 1'b0; smp_is_cur = 1'b0; smp_code = 12'h020;
    @(negedge clk);
    reg_wr_en = 1'b0; smp_vld = 1'b0;
    chk("R11 alarm low", {15'd0, alarm_o}, 16'h0000);
    rd_chk("R11 flags zero", A_FLG, 16'h0000);
    rd_chk("R11 TH0 restored", A_TH0, 16'h07FF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_write_masks();
    t_temp_cmp();
    t_cur_cmp();
    t_sticky_int();
    t_cmp_mode();
    t_disabled();
    t_read_race();
    t_soft_clear();
    t_clear_race();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_vec++;
      n_err++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
    end
  end
endmodule